// File: doc/BRIEF.md
# Frame-Granular Receive Queue with Shadow Readout

This block buffers received controller frames and hands them to a processor one whole frame at a time. Each frame is held as four 32-bit words: identifier, length code, first data word and second data word. The receive logic delivers a complete frame in a single cycle with a valid strobe. The processor reads frames through a small register port.

Reading the identifier address removes the oldest frame from the queue in one step. That read copies all four words into shadow readout registers and returns the new identifier. The length and data addresses then return the shadow copies without touching the queue. An identifier read with no complete frame stored pops nothing and sets a sticky underflow flag. A frame that arrives when the queue has no room for four more words is discarded whole and sets a sticky overflow flag.

A per-bit enable register selects which status bits drive the interrupt output.

Top module: `rxq_frame_reader`

## Requirements
- R1: An incoming frame (`frame_valid` high for one cycle) is stored whole when at least four word slots are free, and the word level read at address 7 rises by exactly 4. The level is always a multiple of 4 and never exceeds 4*DEPTH_FRAMES.
- R2: A read of address 0 with at least one frame stored pops the oldest frame. All four words are latched into the shadow registers, `rdata` returns that frame's identifier, and the level falls by 4.
- R3: A read of address 0 with fewer than four words stored pops nothing. The shadow registers keep their values, `rdata` returns the previous identifier, and status bit 1 (underflow) is set.
- R4: Reads of address 2 (data word 1) and address 3 (data word 2) return the words latched at the last successful identifier read, and they do not change the queue.
- R5: A read of address 1 returns the latched length word with bits 27 to 16 forced to zero, and it does not change the queue.
- R6: Writes to addresses 0 to 3 have no effect on the shadow registers or on the queue.
- R7: A frame that arrives while fewer than four word slots are free is dropped whole, and status bit 2 (overflow) is set. Free space is judged before any pop in the same cycle.
- R8: Status bit 0 (not empty) at address 4 is high exactly when at least one frame is stored. Bits 1 and 2 are the sticky underflow and overflow flags.
- R9: `irq` is the OR of status bits ANDed with the enable bits [2:0] written at address 5. It reflects an underflow in the cycle right after the identifier read that caused it.
- R10: Writing 1 to bit 1 or bit 2 at address 6 clears the matching sticky flag. If the flag's condition occurs in the same cycle, the flag stays set. Address 6 reads as zero.
- R11: Synchronous reset empties the queue, zeroes the shadow registers, and clears the status flags and the enables.
- R12: A read request on `rd_en` and `rd_addr` shows up on `rdata` one clock later, and `rdata` holds between reads. A write and a read may occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe: a complete frame is offered |
| frame_id | input | 32 | Identifier word of the offered frame |
| frame_len | input | 32 | Length-code word of the offered frame |
| frame_d1 | input | 32 | First data word of the offered frame |
| frame_d2 | input | 32 | Second data word of the offered frame |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 3 | Register read address |
| rdata | output | 32 | Registered read data |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 3 | Register write address |
| wdata | input | 32 | Register write data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a single cycle that combines several events: an identifier read on an empty queue while the processor clears the underflow flag, or a frame arriving at a full queue while a pop frees a slot. Either outcome depends on which event takes precedence. Directed steps drive a read and a write in the same cycle to force both orderings. Seeded random traffic then mixes pushes, reads and writes to every address, so overflow and underflow recur many times at varying fill levels. The bench's queue model predicts every readout and every `irq` value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] id;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] d1;
        logic [WORD_W-1:0] d2;
    } rxq_frame_t;

    typedef enum logic [2:0] {
        RA_ID   = 3'd0,
        RA_LEN  = 3'd1,
        RA_D1   = 3'd2,
        RA_D2   = 3'd3,
        RA_STAT = 3'd4,
        RA_IEN  = 3'd5,
        RA_ICLR = 3'd6,
        RA_LVL  = 3'd7
    } rxq_addr_e;

    localparam int ST_W      = 3;
    localparam int ST_NEMPTY = 0;
    localparam int ST_UDF    = 1;
    localparam int ST_OVF    = 2;

    localparam logic [WORD_W-1:0] LEN_KEEP = 32'hF000_FFFF;

    function automatic logic [WORD_W-1:0] len_clean(input logic [WORD_W-1:0] v);
        return v & LEN_KEEP;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH_FRAMES = 8,
    localparam int PTR_W = (DEPTH_FRAMES > 1) ? $clog2(DEPTH_FRAMES) : 1,
    localparam int CNT_W = $clog2(DEPTH_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  rxq_frame_t       push_frame,
    input  logic             pop_req,
    output rxq_frame_t       head,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W+1:0] words
);
    rxq_frame_t        mem [DEPTH_FRAMES];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              full, empty;

    assign full    = (cnt == CNT_W'(DEPTH_FRAMES));
    assign empty   = (cnt == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = mem[rd_ptr];
    assign words   = {cnt, 2'b00};

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH_FRAMES - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/rxq_shadow.sv
module rxq_shadow
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  rxq_frame_t src,
    output rxq_frame_t shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (load) begin
            shadow.id  <= src.id;
            shadow.len <= len_clean(src.len);
            shadow.d1  <= src.d1;
            shadow.d2  <= src.d2;
        end
    end
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            nonempty,
    input  logic            set_udf,
    input  logic            set_ovf,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_bits,
    input  logic            ien_we,
    input  logic [ST_W-1:0] ien_bits,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] ien,
    output logic            irq
);
    logic udf_q, ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            udf_q <= 1'b0;
            ovf_q <= 1'b0;
            ien   <= '0;
        end else begin
            if (set_udf)                      udf_q <= 1'b1;
            else if (clr_we && clr_bits[ST_UDF]) udf_q <= 1'b0;
            if (set_ovf)                      ovf_q <= 1'b1;
            else if (clr_we && clr_bits[ST_OVF]) ovf_q <= 1'b0;
            if (ien_we) ien <= ien_bits;
        end
    end

    always_comb begin
        status            = '0;
        status[ST_NEMPTY] = nonempty;
        status[ST_UDF]    = udf_q;
        status[ST_OVF]    = ovf_q;
    end

    assign irq = |(status & ien);
endmodule

// File: rtl/rxq_frame_reader.sv
module rxq_frame_reader
    import rxq_pkg::*;
#(
    parameter int DEPTH_FRAMES = 8,
    localparam int CAP_WORDS = DEPTH_FRAMES * 4,
    localparam int LVL_W = $clog2(DEPTH_FRAMES + 1) + 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_valid,
    input  logic [31:0] frame_id,
    input  logic [31:0] frame_len,
    input  logic [31:0] frame_d1,
    input  logic [31:0] frame_d2,
    input  logic        rd_en,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rdata,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wdata,
    output logic        irq
);
    rxq_frame_t        in_frame, head, shadow;
    logic              push_ok, pop_ok, id_rd;
    logic [LVL_W-1:0]  words;
    logic [ST_W-1:0]   status, ien;
    logic [31:0]       rd_next;

    assign in_frame = '{id: frame_id, len: frame_len, d1: frame_d1, d2: frame_d2};
    assign id_rd    = rd_en && (rxq_addr_e'(rd_addr) == RA_ID);

    rxq_store #(.DEPTH_FRAMES(DEPTH_FRAMES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_req   (frame_valid),
        .push_frame (in_frame),
        .pop_req    (id_rd),
        .head       (head),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .words      (words)
    );

    rxq_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (pop_ok),
        .src    (head),
        .shadow (shadow)
    );

    rxq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .nonempty (words != '0),
        .set_udf  (id_rd && !pop_ok),
        .set_ovf  (frame_valid && !push_ok),
        .clr_we   (wr_en && (rxq_addr_e'(wr_addr) == RA_ICLR)),
        .clr_bits (wdata[ST_W-1:0]),
        .ien_we   (wr_en && (rxq_addr_e'(wr_addr) == RA_IEN)),
        .ien_bits (wdata[ST_W-1:0]),
        .status   (status),
        .ien      (ien),
        .irq      (irq)
    );

    always_comb begin
        case (rxq_addr_e'(rd_addr))
            RA_ID:   rd_next = pop_ok ? head.id : shadow.id;
            RA_LEN:  rd_next = shadow.len;
            RA_D1:   rd_next = shadow.d1;
            RA_D2:   rd_next = shadow.d2;
            RA_STAT: rd_next = 32'(status);
            RA_IEN:  rd_next = 32'(ien);
            RA_ICLR: rd_next = '0;
            RA_LVL:  rd_next = 32'(words);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/rxq_frame_reader_chk.sv
module rxq_frame_reader_chk #(
    parameter int LVL_W = 6,
    parameter int CAP_WORDS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_valid,
    input logic             rd_en,
    input logic [2:0]       rd_addr,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             irq,
    input logic [LVL_W-1:0] level,
    input logic [2:0]       status,
    input logic [2:0]       ien,
    input logic [31:0]      sh_id
);
    p_level_quantum_r1: assert property (@(posedge clk) disable iff (rst)
        level[1:0] == 2'b00 && level <= LVL_W'(CAP_WORDS));

    p_pop_four_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == 3'd0 && level != '0 && !frame_valid
        |=> level == $past(level) - LVL_W'(4));

    p_udf_flag_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == 3'd0 && level == '0 |=> status[1]);

    p_udf_keep_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == 3'd0 && level == '0 |=> $stable(sh_id));

    p_len_rsvd_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == 3'd1 |=> rdata[27:16] == 12'h000);

    p_ovf_flag_r7: assert property (@(posedge clk) disable iff (rst)
        frame_valid && level == LVL_W'(CAP_WORDS) |=> status[2] && level <= $past(level));

    p_irq_udf_r9: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == 3'd0 && level == '0 && ien[1] && !(wr_en && wr_addr == 3'd5)
        |=> irq);

    p_clear_ovf_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == 3'd6 && wdata[2] && !frame_valid |=> !status[2]);

    p_reset_r11: assert property (@(posedge clk)
        rst |=> level == '0 && status == 3'b000 && !irq);
endmodule

bind rxq_frame_reader rxq_frame_reader_chk #(.LVL_W(LVL_W), .CAP_WORDS(CAP_WORDS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq         (irq),
    .level       (words),
    .status      (status),
    .ien         (ien),
    .sh_id       (shadow.id)
);

// File: tb/rxq_frame_reader_test.sv
module rxq_frame_reader_test;
    import rxq_pkg::*;

    localparam int DEPTH = 8;
    localparam logic [31:0] MASK = 32'hF000_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [31:0] frame_id = '0, frame_len = '0, frame_d1 = '0, frame_d2 = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rdata;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wdata = '0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    rxq_frame_t m_q[$];
    rxq_frame_t m_sh;
    bit         m_udf, m_ovf;
    logic [2:0] m_ien;

    always #2 clk = ~clk;

    rxq_frame_reader #(.DEPTH_FRAMES(DEPTH)) uut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid),
        .frame_id(frame_id), .frame_len(frame_len), .frame_d1(frame_d1), .frame_d2(frame_d2),
        .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic rxq_frame_t rand_frame();
        rxq_frame_t f;
        f.id = $urandom; f.len = $urandom; f.d1 = $urandom; f.d2 = $urandom;
        return f;
    endfunction

    function automatic logic [2:0] model_status();
        return {m_ovf, m_udf, m_q.size() != 0};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_q.delete();
        m_sh = '0; m_udf = 0; m_ovf = 0; m_ien = '0;
    endtask

    task automatic step(input bit dp, input rxq_frame_t f, input bit dr, input logic [2:0] ra,
                        input bit dw, input logic [2:0] wa, input logic [31:0] wd, input string tag);
        logic [31:0] exp;
        string t;
        int n;
        bit full, set_u, set_o;
        frame_valid = dp; frame_id = f.id; frame_len = f.len; frame_d1 = f.d1; frame_d2 = f.d2;
        rd_en = dr; rd_addr = ra; wr_en = dw; wr_addr = wa; wdata = wd;
        n = m_q.size(); full = (n == DEPTH); exp = '0; t = tag; set_u = 0; set_o = 0;
        if (dr) begin
            case (ra)
                3'd0: begin
                    if (n > 0) begin
                        m_sh = m_q.pop_front(); m_sh.len = m_sh.len & MASK;
                        if (t == "") t = "R2";
                    end else begin
                        set_u = 1;
                        if (t == "") t = "R3";
                    end
                    exp = m_sh.id;
                end
                3'd1: begin exp = m_sh.len; if (t == "") t = "R5"; end
                3'd2: begin exp = m_sh.d1;  if (t == "") t = "R4"; end
                3'd3: begin exp = m_sh.d2;  if (t == "") t = "R4"; end
                3'd4: begin exp = {29'b0, m_ovf, m_udf, n != 0}; if (t == "") t = "R8"; end
                3'd5: begin exp = {29'b0, m_ien}; if (t == "") t = "R9"; end
                3'd6: begin exp = '0; if (t == "") t = "R10"; end
                default: begin exp = 32'(n * 4); if (t == "") t = "R1"; end
            endcase
        end
        if (dp) begin
            if (full) set_o = 1;
            else m_q.push_back(f);
        end
        if (dw && wa == 3'd5) m_ien = wd[2:0];
        if (dw && wa == 3'd6) begin
            if (wd[1]) m_udf = 0;
            if (wd[2]) m_ovf = 0;
        end
        if (set_u) m_udf = 1;
        if (set_o) m_ovf = 1;
        @(posedge clk);
        @(negedge clk);
        frame_valid = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        if (dr) check(t, rdata, exp);
        check("R9", {31'b0, irq}, {31'b0, |(model_status() & m_ien)});
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(0, '0, 1, a, 0, 3'd0, '0, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(0, '0, 0, 3'd0, 1, a, d, "");
    endtask

    task automatic push(input rxq_frame_t f);
        step(1, f, 0, 3'd0, 0, 3'd0, '0, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R12 watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20231124));
        do_reset();
        // R11: state after reset
        check("R11", {31'b0, irq}, 32'd0);
        rd(3'd7, "R11");
        rd(3'd4, "R11");
        rd(3'd1, "R11");
        // R3 on empty queue, then R9 with enables
        rd(3'd0, "R3");
        wr(3'd5, 32'h7);
        rd(3'd5, "R9");
        wr(3'd6, 32'h6);
        rd(3'd4, "R10");
        // R1, R7: fill past capacity
        for (int i = 0; i < DEPTH + 2; i++) push(rand_frame());
        rd(3'd7, "R1");
        rd(3'd4, "R7");
        // R2 then R6: writes to readout addresses ignored
        rd(3'd0, "R2");
        for (int a = 0; a < 4; a++) wr(3'(a), $urandom);
        rd(3'd1, "R6");
        rd(3'd2, "R6");
        rd(3'd3, "R6");
        rd(3'd7, "R6");
        // R7: arrival at full queue with pop in the same cycle is dropped
        push(rand_frame());
        step(1, rand_frame(), 1, 3'd0, 0, 3'd0, '0, "R7");
        rd(3'd7, "R7");
        // drain with all readouts
        for (int i = 0; i < DEPTH; i++) begin
            rd(3'd0, "");
            rd(3'd1, "R5");
            rd(3'd2, "R4");
            rd(3'd3, "R4");
        end
        // R10: set wins over clear in the same cycle
        wr(3'd6, 32'h6);
        step(0, '0, 1, 3'd0, 1, 3'd6, 32'h2, "R10");
        rd(3'd4, "R10");
        wr(3'd6, 32'h2);
        rd(3'd4, "R10");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, rand_frame(), $urandom % 2, 3'($urandom),
                 ($urandom % 5) == 0, 3'($urandom), $urandom, "");
        end
        // R11: reset with content present
        for (int i = 0; i < 3; i++) push(rand_frame());
        wr(3'd5, 32'h7);
        do_reset();
        check("R11", {31'b0, irq}, 32'd0);
        rd(3'd7, "R11");
        rd(3'd5, "R11");
        rd(3'd2, "R11");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule